// File: doc/BRIEF.md
# Master-Checker Lockstep Comparator

This block pairs two identical copies of a logic function that run in lockstep. Each cycle it takes in the output vector and the per-bit output enables of both copies. One copy is the master: its registered vector becomes the shared output bus. The other copy is the checker. It never reaches the bus. Instead, it compares the value it would have driven with the value the master actually puts on the bus.

A role strap picks which copy is the master. The strap is taken on the first clock edge after reset is released and has no effect after that. When the checker sees any disagreement on a bit it has enabled, or any disagreement in the enables themselves, a sticky error is raised. That error immediately withdraws every output enable of the master. Drive stays withdrawn until software pulses a synchronous clear, or until reset.

Top module: `lockstep_pair_cmp`

## Requirements
- R1: While reset is asserted, and immediately after it, `pad_oe_o` is all zero, `pad_data_o` is all zero and `err_o` is low.
- R2: On the first rising edge after reset release, `role_strap_i` is sampled. A value of 0 makes copy A the master and copy B the checker. A value of 1 makes copy B the master and copy A the checker. Later changes of the strap have no effect until the next reset.
- R3: After the sampling edge, `pad_data_o` shows the master copy's data vector one clock after it was presented. While no error is held, `pad_oe_o` shows the master's enable vector with the same one-cycle delay.
- R4: The checker copy never drives. `pad_data_o` carries only the master's data, even in a cycle where the checker's data differs from it.
- R5: A mismatch is raised in a cycle when either of these holds for the registered vectors: (a) an enabled checker bit has data that differs from the master's bus data, or (b) an enable bit differs between the two copies. `err_o` goes high on the following clock edge.
- R6: A data difference on a bit whose checker enable is 0 does not raise an error, as long as the enables of both copies agree.
- R7: `err_o` stays high until `err_clr_i` is sampled high. It then goes low on that edge, unless a mismatch is being registered on the same edge, in which case the mismatch wins and `err_o` stays high.
- R8: While `err_o` is high, `pad_oe_o` is all zero. `pad_oe_o` drops on the same edge where `err_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| role_strap_i | input | 1 | Role select, sampled once after reset: 0 = copy A is master, 1 = copy B is master |
| a_data_i | input | W | Output data vector of copy A |
| a_oe_i | input | W | Per-bit output enable of copy A |
| b_data_i | input | W | Output data vector of copy B |
| b_oe_i | input | W | Per-bit output enable of copy B |
| err_clr_i | input | 1 | Synchronous clear of the sticky error |
| pad_data_o | output | W | Data on the shared bus (master copy, registered) |
| pad_oe_o | output | W | Bus output enables, forced low while the error is held |
| err_o | output | 1 | Sticky lockstep mismatch flag |

## Verification
Two situations are hard to reach from the ports. The first is a clear pulse that lands on the same edge as a fresh mismatch. The bench makes it happen with an enable-only disagreement in one row, followed at once by a row that requests a clear, so both land on the same edge.

The second is that checker-masked bits must be ignored. Rows where the data of the two copies differs only under a zero checker enable show this. Rows where only one enable bit differs show that enable disagreement alone trips the error.

Role selection is proven by vectors whose data differs only in masked bits, so the bus value shows which copy is driving. The strap is then flipped after the sampling edge, and the bus must still show the same copy.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Which copy owns the shared bus after the strap is taken.
  typedef enum logic {
    MST_A = 1'b0,
    MST_B = 1'b1
  } master_sel_e;

  localparam int unsigned NUM_COPIES = 2;

endpackage

// File: rtl/lsc_lane_reg.sv
// Output register stage for one replicated copy: data plus enables.
module lsc_lane_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] oe_in,
  output logic [W-1:0] d_q,
  output logic [W-1:0] oe_q
);

  logic [W-1:0] d_nxt;
  logic [W-1:0] oe_nxt;

  always_comb begin
    d_nxt  = d_q;
    oe_nxt = oe_q;
    if (cap_en) begin
      d_nxt  = d_in;
      oe_nxt = oe_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= '0;
      oe_q <= '0;
    end else begin
      d_q  <= d_nxt;
      oe_q <= oe_nxt;
    end
  end

endmodule

// File: rtl/lsc_role_ctl.sv
// Takes the role strap once on the first edge after reset, then freezes it.
module lsc_role_ctl
  import lsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_i,
  output logic        armed_o,
  output master_sel_e role_o
);

  logic        armed_q;
  logic        armed_nxt;
  master_sel_e role_q;
  master_sel_e role_nxt;

  always_comb begin
    armed_nxt = armed_q;
    role_nxt  = role_q;
    if (!armed_q) begin
      armed_nxt = 1'b1;
      role_nxt  = master_sel_e'(strap_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      role_q  <= MST_A;
    end else begin
      armed_q <= armed_nxt;
      role_q  <= role_nxt;
    end
  end

  assign armed_o = armed_q;
  assign role_o  = role_q;

  // R2: once taken, the role never moves and the block stays armed
  a_r2_role_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> (armed_q && $stable(role_q)));

endmodule

// File: rtl/lsc_mask_cmp.sv
// Checker-side comparison: would-be value versus observed bus value,
// masked by the checker's enables, plus a check of the enable vectors.
module lsc_mask_cmp #(
  parameter int unsigned W   = 8,
  parameter int unsigned GRP = 4
) (
  input  logic         en_i,
  input  logic [W-1:0] chk_d_i,
  input  logic [W-1:0] chk_oe_i,
  input  logic [W-1:0] bus_d_i,
  input  logic [W-1:0] mst_oe_i,
  output logic         mism_o
);

  localparam int unsigned NGRP = (W + GRP - 1) / GRP;

  logic [W-1:0]    diff_bits;
  logic [NGRP-1:0] grp_hit;

  always_comb begin
    diff_bits = ((chk_d_i ^ bus_d_i) & chk_oe_i) | (chk_oe_i ^ mst_oe_i);
  end

  // Reduction split into groups to keep the OR tree shallow and regular.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned LO = g * GRP;
    localparam int unsigned HI = ((g + 1) * GRP > W) ? (W - 1) : ((g + 1) * GRP - 1);
    assign grp_hit[g] = |diff_bits[HI:LO];
  end

  assign mism_o = en_i & (|grp_hit);

endmodule

// File: rtl/lsc_err_hold.sv
// Sticky mismatch flag with synchronous clear; a new mismatch beats clear.
module lsc_err_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic mism_i,
  input  logic clr_i,
  output logic err_o
);

  logic err_q;
  logic err_nxt;

  always_comb begin
    err_nxt = err_q;
    if (clr_i) begin
      err_nxt = 1'b0;
    end
    if (mism_i) begin
      err_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
    end
  end

  assign err_o = err_q;

  // R5: a registered mismatch raises the flag on the next edge
  a_r5_mismatch_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    mism_i |=> err_o);

  // R7: the flag holds until a clear is seen
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);

  // R7: a clear without a competing mismatch drops the flag
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !mism_i) |=> !err_o);

  // R5: the flag never rises without a mismatch
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && !mism_i) |=> !err_o);

endmodule

// File: rtl/lockstep_pair_cmp.sv
// Master-checker lockstep comparator for two replicated copies.
module lockstep_pair_cmp
  import lsc_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         role_strap_i,
  input  logic [W-1:0] a_data_i,
  input  logic [W-1:0] a_oe_i,
  input  logic [W-1:0] b_data_i,
  input  logic [W-1:0] b_oe_i,
  input  logic         err_clr_i,
  output logic [W-1:0] pad_data_o,
  output logic [W-1:0] pad_oe_o,
  output logic         err_o
);

  logic        armed;
  master_sel_e role;
  logic        mism;
  logic        err_q;

  logic [W-1:0] cp_d_in  [NUM_COPIES];
  logic [W-1:0] cp_oe_in [NUM_COPIES];
  logic [W-1:0] cp_d_q   [NUM_COPIES];
  logic [W-1:0] cp_oe_q  [NUM_COPIES];

  logic [W-1:0] mst_d;
  logic [W-1:0] mst_oe;
  logic [W-1:0] chk_d;
  logic [W-1:0] chk_oe;

  assign cp_d_in[0]  = a_data_i;
  assign cp_oe_in[0] = a_oe_i;
  assign cp_d_in[1]  = b_data_i;
  assign cp_oe_in[1] = b_oe_i;

  lsc_role_ctl u_role (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (role_strap_i),
    .armed_o (armed),
    .role_o  (role)
  );

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    lsc_lane_reg #(.W(W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (1'b1),
      .d_in   (cp_d_in[c]),
      .oe_in  (cp_oe_in[c]),
      .d_q    (cp_d_q[c]),
      .oe_q   (cp_oe_q[c])
    );
  end

  // Role steering: master feeds the bus, checker feeds the comparator.
  always_comb begin
    if (role == MST_B) begin
      mst_d  = cp_d_q[1];
      mst_oe = cp_oe_q[1];
      chk_d  = cp_d_q[0];
      chk_oe = cp_oe_q[0];
    end else begin
      mst_d  = cp_d_q[0];
      mst_oe = cp_oe_q[0];
      chk_d  = cp_d_q[1];
      chk_oe = cp_oe_q[1];
    end
  end

  // The checker observes what is actually placed on the bus data lines.
  lsc_mask_cmp #(.W(W), .GRP(GRP)) u_cmp (
    .en_i     (armed),
    .chk_d_i  (chk_d),
    .chk_oe_i (chk_oe),
    .bus_d_i  (pad_data_o),
    .mst_oe_i (mst_oe),
    .mism_o   (mism)
  );

  lsc_err_hold u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .mism_i (mism),
    .clr_i  (err_clr_i),
    .err_o  (err_q)
  );

  assign pad_data_o = mst_d;
  assign pad_oe_o   = (armed && !err_q) ? mst_oe : '0;
  assign err_o      = err_q;

  // R8: a held error leaves no enable active on the bus
  a_r8_oe_off_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (pad_oe_o == '0));

  // R3/R4: bus data is copy A's vector one cycle later when A is master
  a_r3_bus_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && role == MST_A) |=> (pad_data_o == $past(a_data_i)));

  // R3/R4: bus data is copy B's vector one cycle later when B is master
  a_r4_bus_from_b: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && role == MST_B) |=> (pad_data_o == $past(b_data_i)));

endmodule

// File: tb/lockstep_pair_cmp_tb_top.sv
`timescale 1ns/1ps
module lockstep_pair_cmp_tb_top;

  localparam int unsigned W = 8;
  localparam int NROWS = 13;

  typedef struct packed {
    logic [7:0] ad;
    logic [7:0] aoe;
    logic [7:0] bd;
    logic [7:0] boe;
    logic       clr;
    logic [7:0] ed;
    logic [7:0] eoe;
    logic       eerr;
  } row_t;

  // Strap 0: copy A is master. Expected outputs are sampled after the edge
  // that captures the row; err reflects mismatches from earlier rows.
  localparam row_t TBL [NROWS] = '{
    '{8'h5A, 8'hFF, 8'h5A, 8'hFF, 1'b0, 8'h5A, 8'hFF, 1'b0}, // R3 agree
    '{8'hC3, 8'hF0, 8'hC3, 8'hF0, 1'b0, 8'hC3, 8'hF0, 1'b0}, // R3 partial oe
    '{8'hA5, 8'h0F, 8'hB5, 8'h0F, 1'b0, 8'hA5, 8'h0F, 1'b0}, // R6 masked diff
    '{8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0}, // R6 all masked
    '{8'h11, 8'hFF, 8'h11, 8'hFF, 1'b0, 8'h11, 8'hFF, 1'b0}, // R6 no error
    '{8'h12, 8'hFF, 8'h13, 8'hFF, 1'b0, 8'h12, 8'hFF, 1'b0}, // R4 data diff
    '{8'h22, 8'hFF, 8'h22, 8'hFF, 1'b0, 8'h22, 8'h00, 1'b1}, // R5 R8
    '{8'h33, 8'hFF, 8'h33, 8'hFF, 1'b0, 8'h33, 8'h00, 1'b1}, // R7 sticky
    '{8'h44, 8'hFF, 8'h44, 8'hFF, 1'b1, 8'h44, 8'hFF, 1'b0}, // R7 clear
    '{8'h55, 8'h0F, 8'h55, 8'h0E, 1'b0, 8'h55, 8'h0F, 1'b0}, // R5 oe diff
    '{8'h66, 8'hFF, 8'h66, 8'hFF, 1'b1, 8'h66, 8'h00, 1'b1}, // R7 mism wins
    '{8'h77, 8'hFF, 8'h77, 8'hFF, 1'b1, 8'h77, 8'hFF, 1'b0}, // R7 clear
    '{8'h88, 8'hFF, 8'h88, 8'hFF, 1'b0, 8'h88, 8'hFF, 1'b0}  // R3 steady
  };

  logic         clk;
  logic         rst_n;
  logic         strap;
  logic [W-1:0] a_d, a_oe, b_d, b_oe;
  logic         clr;
  logic [W-1:0] pad_d, pad_oe;
  logic         err;

  int n_chk;
  int n_fail;
  bit done;

  lockstep_pair_cmp #(.W(W), .GRP(4)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .role_strap_i (strap),
    .a_data_i     (a_d),
    .a_oe_i       (a_oe),
    .b_data_i     (b_d),
    .b_oe_i       (b_oe),
    .err_clr_i    (clr),
    .pad_data_o   (pad_d),
    .pad_oe_o     (pad_oe),
    .err_o        (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string row_req(int i);
    case (i)
      2, 3, 4: return "R6";
      5:       return "R4";
      6:       return "R8";
      9:       return "R5";
      7, 8, 10, 11: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] ad, logic [7:0] aoe, logic [7:0] bd,
                       logic [7:0] boe, logic c);
    a_d = ad; a_oe = aoe; b_d = bd; b_oe = boe; clr = c;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; strap = 1'b0;
    drive(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet in reset
    chk("R1", "pad_oe in reset", 32'(pad_oe), 32'h0);
    chk("R1", "pad_data in reset", 32'(pad_d), 32'h0);
    chk("R1", "err in reset", 32'(err), 32'h0);

    // Table walk with copy A as master (R2 strap 0)
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].ad, TBL[i].aoe, TBL[i].bd, TBL[i].boe, TBL[i].clr);
      @(posedge clk);
      #1;
      chk(row_req(i), $sformatf("row %0d pad_data", i), 32'(pad_d), 32'(TBL[i].ed));
      chk(row_req(i), $sformatf("row %0d pad_oe", i), 32'(pad_oe), 32'(TBL[i].eoe));
      chk(row_req(i), $sformatf("row %0d err", i), 32'(err), 32'(TBL[i].eerr));
      @(negedge clk);
    end

    // R1: reset mid-run with an error pending clears everything
    drive(8'h00, 8'hFF, 8'h01, 8'hFF, 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive(8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0);
    @(posedge clk); #1;
    chk("R5", "err before reset", 32'(err), 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "err after async reset", 32'(err), 32'h0);
    chk("R1", "pad_oe after async reset", 32'(pad_oe), 32'h0);
    chk("R1", "pad_data after async reset", 32'(pad_d), 32'h0);

    // R2: strap 1 makes copy B master; data differs only in masked bits
    strap = 1'b1;
    @(negedge clk);
    drive(8'h0F, 8'h0F, 8'hFF, 8'h0F, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2", "B master pad_data", 32'(pad_d), 32'hFF);
    chk("R2", "B master pad_oe", 32'(pad_oe), 32'h0F);
    @(negedge clk);
    strap = 1'b0;   // R2: ignored after sampling
    drive(8'h01, 8'h0F, 8'hF1, 8'h0F, 1'b0);
    @(posedge clk); #1;
    chk("R2", "strap change ignored", 32'(pad_d), 32'hF1);
    chk("R6", "checker A masked bits no err", 32'(err), 32'h0);
    @(negedge clk);
    @(posedge clk); #1;
    chk("R6", "still no err", 32'(err), 32'h0);
    chk("R3", "pad_oe with B master", 32'(pad_oe), 32'h0F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule